// File: doc/BRIEF.md
# Real-Time Clock Interrupt Status Register

This block holds the interrupt status of a real-time clock. Three event sources feed it: the rising edge of a chosen divider tap (the periodic tick), a strobe from the alarm comparator when the time matches the alarm, and a strobe at the end of each time update. Each event sets a sticky flag whether or not its enable is on. The flags are presented, together with a summary bit, as a read-only status byte.

A flag whose enable is also set raises the summary bit and pulls the active-low interrupt pin. Reading the status byte returns the flags as they stood and clears all three of them at once. A second read-only byte reports whether the backup battery is healthy. The divider chain, the time counters, the alarm comparison and the bus protocol sit outside this block. The block only sees event strobes, enable levels, a read strobe with a byte select, and reset.

Top module: `rtc_irq_status`

## Requirements
- R1: With `rd_sel`=0, a read strobe loads `rd_data` on the next clock edge with the status byte: bit 7 summary IRQ, bit 6 periodic flag, bit 5 alarm flag, bit 4 update flag, and bits 3..0 always 0. `rd_data` then holds until the next read.
- R2: A rising edge on `tap_in` (low in one cycle, high in the next) sets the periodic flag, whatever the state of `en_periodic`.
- R3: `alarm_hit` sets the alarm flag and `update_done` sets the update flag, whatever the state of their enables.
- R4: `irq_n` is low exactly when some flag is set together with its enable. Raising an enable while its flag is set drives `irq_n` low in the same cycle, without waiting for a clock.
- R5: A status-byte read clears all three flags, so `irq_n` returns high after that clock edge.
- R6: A read returns the flag values from before the clear. An event that arrives in the same cycle as the clearing read leaves its flag set afterwards.
- R7: A synchronous reset (`rst`=1) clears the flags and `rd_data` to 0, which leaves `irq_n` high.
- R8: With `rd_sel`=1, a read returns `batt_ok` in bit 7 and 0 in bits 6..0. This read does not clear the flags, and reset does not alter what it reports.
- R9: Flags stay set until a status-byte read or a reset. A tap held high after its edge does not set the periodic flag again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tap_in | input | 1 | Level of the selected divider tap |
| alarm_hit | input | 1 | One-cycle strobe: time equals alarm time |
| update_done | input | 1 | One-cycle strobe: time update finished |
| en_periodic | input | 1 | Periodic interrupt enable |
| en_alarm | input | 1 | Alarm interrupt enable |
| en_update | input | 1 | Update-ended interrupt enable |
| rd_stb | input | 1 | Read strobe |
| rd_sel | input | 1 | Byte select: 0 status, 1 battery |
| batt_ok | input | 1 | Battery health, 1 = good |
| rd_data | output | 8 | Registered read data |
| irq_n | output | 1 | Active-low interrupt output |

## Verification
The assertions assume that the tap input and the event strobes are synchronous to `clk` and change only between edges. They also assume that `rd_stb` is a single-cycle pulse. The bench drives every input on the falling edge and raises each strobe for exactly one cycle. It keeps `tap_in` low through reset, so that no spurious edge appears when reset is released. Same-cycle collisions between a read and an event are produced on purpose, to exercise the case where a flag must survive its clearing read.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;
  localparam int DATA_W   = 8;
  localparam int NUM_EV   = 3;   // index 0 update, 1 alarm, 2 periodic
  localparam int POS_IRQ  = 7;
  localparam int POS_EV0  = 4;   // update flag bit; alarm and periodic follow upward
  localparam int POS_BATT = 7;
  localparam logic SEL_STATUS = 1'b0;
  localparam logic SEL_BATT   = 1'b1;
endpackage

// File: rtl/rtc_tap_edge.sv
module rtc_tap_edge (
  input  logic clk,
  input  logic rst,
  input  logic tap_in,
  output logic tap_rise
);
  logic tap_q;

  always_ff @(posedge clk) begin
    if (rst) tap_q <= 1'b0;
    else     tap_q <= tap_in;
  end

  assign tap_rise = tap_in & ~tap_q;

  assert_single_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    tap_rise |=> !tap_rise);
endmodule

// File: rtl/rtc_flag_cell.sv
module rtc_flag_cell (
  input  logic clk,
  input  logic rst,
  input  logic ev,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (rst)      flag <= 1'b0;
    else if (ev)  flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end

  assert_event_sets_R6: assert property (@(posedge clk) disable iff (rst)
    ev |=> flag);
  assert_clear_drops_R5: assert property (@(posedge clk) disable iff (rst)
    (clr && !ev) |=> !flag);
  assert_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    (flag && !clr) |=> flag);
endmodule

// File: rtl/rtc_irq_status.sv
module rtc_irq_status
  import rtc_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              tap_in,
  input  logic              alarm_hit,
  input  logic              update_done,
  input  logic              en_periodic,
  input  logic              en_alarm,
  input  logic              en_update,
  input  logic              rd_stb,
  input  logic              rd_sel,
  input  logic              batt_ok,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq_n
);
  logic              tap_rise;
  logic [NUM_EV-1:0] ev;
  logic [NUM_EV-1:0] en;
  logic [NUM_EV-1:0] flag_q;
  logic              clr_read;
  logic              irq_sum;
  logic [DATA_W-1:0] status_byte;
  logic [DATA_W-1:0] batt_byte;

  rtc_tap_edge u_edge (
    .clk(clk), .rst(rst), .tap_in(tap_in), .tap_rise(tap_rise)
  );

  assign ev       = {tap_rise, alarm_hit, update_done};
  assign en       = {en_periodic, en_alarm, en_update};
  assign clr_read = rd_stb && (rd_sel == SEL_STATUS);

  for (genvar g = 0; g < NUM_EV; g++) begin : g_flag
    rtc_flag_cell u_cell (
      .clk(clk), .rst(rst), .ev(ev[g]), .clr(clr_read), .flag(flag_q[g])
    );
  end

  assign irq_sum = |(flag_q & en);
  assign irq_n   = ~irq_sum;

  always_comb begin
    status_byte          = '0;
    status_byte[POS_IRQ] = irq_sum;
    for (int i = 0; i < NUM_EV; i++) status_byte[POS_EV0 + i] = flag_q[i];
    batt_byte            = '0;
    batt_byte[POS_BATT]  = batt_ok;
  end

  always_ff @(posedge clk) begin
    if (rst)         rd_data <= '0;
    else if (rd_stb) rd_data <= (rd_sel == SEL_BATT) ? batt_byte : status_byte;
  end

  assert_low_nibble_R1: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && rd_sel == SEL_STATUS) |=> rd_data[3:0] == 4'b0);
  assert_release_R5: assert property (@(posedge clk) disable iff (rst)
    (clr_read && ev == '0) |=> irq_n);
  assert_batt_byte_R8: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && rd_sel == SEL_BATT) |=> rd_data == {$past(batt_ok), 7'b0});
  assert_batt_keeps_R8: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && rd_sel == SEL_BATT) |=> flag_q == ($past(flag_q) | $past(ev)));
  assert_tap_sets_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(tap_in) |=> flag_q[2]);
endmodule

// File: tb/test_rtc_irq_status.sv
module test_rtc_irq_status;
  logic clk = 1'b0;
  logic rst, tap_in, alarm_hit, update_done;
  logic en_periodic, en_alarm, en_update, rd_stb, rd_sel, batt_ok;
  logic [7:0] rd_data;
  logic irq_n;
  int n_checks = 0;
  int n_fail   = 0;
  logic [7:0] got;

  always #2 clk = ~clk;

  rtc_irq_status i_rtc_irq_status (
    .clk(clk), .rst(rst), .tap_in(tap_in), .alarm_hit(alarm_hit),
    .update_done(update_done), .en_periodic(en_periodic), .en_alarm(en_alarm),
    .en_update(en_update), .rd_stb(rd_stb), .rd_sel(rd_sel), .batt_ok(batt_ok),
    .rd_data(rd_data), .irq_n(irq_n)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic read_byte(input logic sel, output logic [7:0] val);
    @(negedge clk); rd_stb = 1'b1; rd_sel = sel;
    @(negedge clk); rd_stb = 1'b0; rd_sel = 1'b0;
    val = rd_data;
  endtask

  task automatic pulse_alarm();
    @(negedge clk); alarm_hit = 1'b1;
    @(negedge clk); alarm_hit = 1'b0;
  endtask

  task automatic pulse_update();
    @(negedge clk); update_done = 1'b1;
    @(negedge clk); update_done = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset_state();
    do_reset();
    check("R7 irq_n after reset", {7'b0, irq_n}, 8'h01);
    check("R7 rd_data after reset", rd_data, 8'h00);
    read_byte(1'b0, got); check("R7 status after reset", got, 8'h00);
  endtask

  task automatic t_periodic();
    @(negedge clk); tap_in = 1'b1;
    @(negedge clk);
    check("R2 no irq when disabled", {7'b0, irq_n}, 8'h01);
    read_byte(1'b0, got); check("R2 R1 periodic flag", got, 8'h40);
    repeat (3) @(negedge clk);
    read_byte(1'b0, got); check("R9 held tap no re-set", got, 8'h00);
    @(negedge clk); tap_in = 1'b0;
  endtask

  task automatic t_alarm_update();
    pulse_alarm();
    read_byte(1'b0, got); check("R3 alarm flag", got, 8'h20);
    read_byte(1'b0, got); check("R5 cleared after read", got, 8'h00);
    pulse_update();
    repeat (10) @(negedge clk);
    read_byte(1'b0, got); check("R3 R9 update flag sticky", got, 8'h10);
  endtask

  task automatic t_irq_enable();
    pulse_update();
    check("R4 irq high with enable off", {7'b0, irq_n}, 8'h01);
    en_update = 1'b1; #1;
    check("R4 irq low at once on enable", {7'b0, irq_n}, 8'h00);
    read_byte(1'b0, got); check("R1 R6 summary bit read", got, 8'h90);
    check("R5 irq released after read", {7'b0, irq_n}, 8'h01);
    en_update = 1'b0;
  endtask

  task automatic t_same_cycle();
    pulse_update();
    @(negedge clk); rd_stb = 1'b1; rd_sel = 1'b0; alarm_hit = 1'b1;
    @(negedge clk); rd_stb = 1'b0; alarm_hit = 1'b0;
    check("R6 pre-clear value", rd_data, 8'h10);
    read_byte(1'b0, got); check("R6 collided event kept", got, 8'h20);
  endtask

  task automatic t_battery();
    batt_ok = 1'b1;
    @(negedge clk); tap_in = 1'b1;
    @(negedge clk); tap_in = 1'b0;
    read_byte(1'b1, got); check("R8 battery good", got, 8'h80);
    batt_ok = 1'b0;
    read_byte(1'b1, got); check("R8 battery bad", got, 8'h00);
    read_byte(1'b0, got); check("R8 battery read keeps flags", got, 8'h40);
    batt_ok = 1'b1;
    do_reset();
    read_byte(1'b1, got); check("R8 battery after reset", got, 8'h80);
  endtask

  task automatic t_reset_clears();
    en_periodic = 1'b1; en_alarm = 1'b1; en_update = 1'b1;
    pulse_alarm();
    check("R4 alarm irq", {7'b0, irq_n}, 8'h00);
    do_reset();
    check("R7 irq released by reset", {7'b0, irq_n}, 8'h01);
    read_byte(1'b0, got); check("R7 flags cleared by reset", got, 8'h00);
    en_periodic = 1'b0; en_alarm = 1'b0; en_update = 1'b0;
  endtask

  initial begin
    rst = 1'b1; tap_in = 1'b0; alarm_hit = 1'b0; update_done = 1'b0;
    en_periodic = 1'b0; en_alarm = 1'b0; en_update = 1'b0;
    rd_stb = 1'b0; rd_sel = 1'b0; batt_ok = 1'b1;
    t_reset_state();
    t_periodic();
    t_alarm_update();
    t_irq_enable();
    t_same_cycle();
    t_battery();
    t_reset_clears();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule